// File: doc/BRIEF.md
# Pseudo-random 16QAM test symbol source

This block produces a stream of 16QAM test symbols that a receiver test bench or a link bring-up path can predict exactly. A 7-bit linear feedback shift register with characteristic polynomial 1 + x^3 + x^7 emits one pseudo-random bit on every enabled clock. The bits are collected serially in groups of four. The first two bits of each group choose the in-phase amplitude and the last two choose the quadrature amplitude. Each pair is Gray coded onto the four levels -3, -1, +1 and +3, scaled into signed 8-bit words.

A one-cycle strobe marks each new symbol. The I and Q words keep their values between strobes. When the enable input is low, the generator and the bit collector both freeze. Because the register always starts from the same seed, every symbol after reset is known in advance.

The reset input is asynchronous and active low. Its release passes through a two-stage synchronizer, so the logic comes out of reset on the third rising edge after the input goes high. Users keep the enable input low for those edges.

Top module: `qam16_prbs_src`

## Requirements
- R1: While reset is asserted, and right after it, sym_vld is 0, i_sym and q_sym are 0, and the shift register holds the all-ones seed 7'b1111111.
- R2: On each enabled clock the register state s[6:0] yields bit b = s[6] XOR s[2], and the state becomes {s[5:0], b}. Bits are used in the order they are produced.
- R3: The register never reaches the all-zero state. The bit stream repeats every 127 bits, so from reset under continuous enable the symbol stream repeats every 127 symbols.
- R4: Four consecutive bits form one symbol. sym_vld is high for exactly one cycle, in the cycle after the clock edge that takes the fourth bit, and is never high on two cycles in a row.
- R5: Within a group, bits 1 and 2 form the I code (bit 1 is the MSB) and bits 3 and 4 form the Q code (bit 3 is the MSB). The code-to-word mapping is 2'b00 to -96, 2'b01 to -32, 2'b11 to +32 and 2'b10 to +96, in 8-bit two's complement.
- R6: A clock edge with en low changes no state. The register, the partial bit group, i_sym and q_sym all keep their values, and sym_vld is 0 after that edge.
- R7: Between strobes, i_sym and q_sym keep the values of the last completed symbol.
- R8: The first symbol after reset, under continuous enable, is I = -96 and Q = -32 (bits 0,0,0,1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| en | input | 1 | Advance enable. When low, all state holds |
| i_sym | output | 8 | In-phase amplitude, signed two's complement |
| q_sym | output | 8 | Quadrature amplitude, signed two's complement |
| sym_vld | output | 1 | One-cycle strobe marking a new symbol on i_sym and q_sym |

## Verification
The stream is checked on every clock against a behavioural model. It is tried under several enable patterns:
- **Uninterrupted enable** fixes the bit order, the group boundaries and the Gray map. It also gives a 300-symbol log, which tests the 127-symbol period.
- **Enable gaps at irregular spacing** catch a collector that loses or double-counts a bit when the enable drops partway through a group.
- **A long hold with enable low** separates real state hold from output hold.
- **A reset in the middle of a run** confirms that the seed and the first symbol come back.

// File: rtl/qam_src_pkg.sv
package qam_src_pkg;

  // Seed loaded into the bit generator on reset: all ones.
  function automatic logic [31:0] ones_seed(input int unsigned width);
    logic [31:0] v;
    v = '0;
    for (int unsigned k = 0; k < width; k++) v[k] = 1'b1;
    return v;
  endfunction

  // Gray code to natural binary, for codes up to 8 bits wide.
  function automatic logic [7:0] gray_to_bin(input logic [7:0] g, input int unsigned nbits);
    logic [7:0] b;
    b = '0;
    for (int k = 7; k >= 0; k--) begin
      if (k < int'(nbits)) begin
        if (k == int'(nbits) - 1) b[k] = g[k];
        else                      b[k] = b[k+1] ^ g[k];
      end
    end
    return b;
  endfunction

endpackage

// File: rtl/prbs_lfsr.sv
module prbs_lfsr #(
  parameter int unsigned STATE_W = 7,
  parameter int unsigned TAP_POW = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic bit_o
);
  import qam_src_pkg::*;

  localparam logic [STATE_W-1:0] SEED = STATE_W'(ones_seed(STATE_W));

  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] state_d;
  logic               fb;

  always_comb begin
    fb      = state_q[STATE_W-1] ^ state_q[TAP_POW-1];
    state_d = state_q;
    if (en) state_d = {state_q[STATE_W-2:0], fb};
  end

  assign bit_o = fb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  // R3: the generator never locks up in the all-zero state
  p_state_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

  // R6: an edge with enable low leaves the register untouched
  p_state_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(state_q));

endmodule

// File: rtl/sym_gather.sv
module sym_gather #(
  parameter int unsigned SYM_BITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                bit_i,
  output logic [SYM_BITS-1:0] word_o,
  output logic                done_o
);
  localparam int unsigned CNT_W = $clog2(SYM_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SYM_BITS - 1);

  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [SYM_BITS-2:0] sreg_q, sreg_d;

  always_comb begin
    cnt_d  = cnt_q;
    sreg_d = sreg_q;
    if (en) begin
      cnt_d  = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      sreg_d = {sreg_q[SYM_BITS-3:0], bit_i};
    end
  end

  // Earliest bit sits at the MSB of the assembled word
  assign word_o = {sreg_q, bit_i};
  assign done_o = en && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sreg_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      sreg_q <= sreg_d;
    end
  end

  // R6: the partial group holds while enable is low
  p_group_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(cnt_q) && $stable(sreg_q)));

  // R4: a group completes only after a full count of bits
  p_done_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

// File: rtl/level_map.sv
module level_map #(
  parameter int unsigned CODE_W = 2,
  parameter int unsigned OUT_W  = 8,
  parameter int          UNIT   = 32
) (
  input  logic [CODE_W-1:0]       code_i,
  output logic signed [OUT_W-1:0] level_o
);
  import qam_src_pkg::*;

  localparam int SPAN = (1 << CODE_W) - 1;

  logic [7:0] bin;
  int         lvl;

  always_comb begin
    bin     = gray_to_bin(8'(code_i), CODE_W);
    lvl     = (2 * int'(bin) - SPAN) * UNIT;
    level_o = OUT_W'(lvl);
  end

endmodule

// File: rtl/qam16_prbs_src.sv
module qam16_prbs_src #(
  parameter int unsigned LFSR_W     = 7,
  parameter int unsigned LFSR_TAP   = 3,
  parameter int unsigned AXIS_BITS  = 2,
  parameter int unsigned OUT_W      = 8,
  parameter int          LEVEL_UNIT = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [OUT_W-1:0] i_sym,
  output logic [OUT_W-1:0] q_sym,
  output logic             sym_vld
);
  localparam int unsigned SYM_BITS = 2 * AXIS_BITS;
  localparam int unsigned N_AXES   = 2;

  // Reset: asserts at once, releases on the clock
  logic [1:0] rsync_q, rsync_d;
  logic       rst_s;

  always_comb rsync_d = {rsync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= rsync_d;
  end

  assign rst_s = rsync_q[1];

  logic                prbs_bit;
  logic [SYM_BITS-1:0] word;
  logic                done;

  prbs_lfsr #(.STATE_W(LFSR_W), .TAP_POW(LFSR_TAP)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_s),
    .en    (en),
    .bit_o (prbs_bit)
  );

  sym_gather #(.SYM_BITS(SYM_BITS)) u_gather (
    .clk    (clk),
    .rst_n  (rst_s),
    .en     (en),
    .bit_i  (prbs_bit),
    .word_o (word),
    .done_o (done)
  );

  // Axis 0 (I) takes the earliest pair, axis 1 (Q) the latest pair
  logic signed [OUT_W-1:0] lvl [N_AXES];

  for (genvar a = 0; a < N_AXES; a++) begin : g_axis
    level_map #(.CODE_W(AXIS_BITS), .OUT_W(OUT_W), .UNIT(LEVEL_UNIT)) u_map (
      .code_i  (word[SYM_BITS-1-a*AXIS_BITS -: AXIS_BITS]),
      .level_o (lvl[a])
    );
  end

  logic [OUT_W-1:0] i_q, i_d, q_q, q_d;
  logic             vld_q, vld_d;

  always_comb begin
    i_d   = i_q;
    q_d   = q_q;
    vld_d = 1'b0;
    if (done) begin
      i_d   = lvl[0];
      q_d   = lvl[1];
      vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      i_q   <= '0;
      q_q   <= '0;
      vld_q <= 1'b0;
    end else begin
      i_q   <= i_d;
      q_q   <= q_d;
      vld_q <= vld_d;
    end
  end

  assign i_sym   = i_q;
  assign q_sym   = q_q;
  assign sym_vld = vld_q;

  // R4: the strobe never lasts two cycles
  p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_s)
    sym_vld |=> !sym_vld);

  // R6: enable low freezes the outputs and drops the strobe
  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_s)
    !en |=> (!sym_vld && $stable(i_sym) && $stable(q_sym)));

  // R7: the words only move together with a strobe
  p_words_move_with_strobe_r7: assert property (@(posedge clk) disable iff (!rst_s)
    !sym_vld |-> ($stable(i_sym) && $stable(q_sym)));

  // R5: every issued word is one of the four legal levels
  if (AXIS_BITS == 2) begin : g_chk_levels
    localparam logic [OUT_W-1:0] LV_P3 = OUT_W'(3 * LEVEL_UNIT);
    localparam logic [OUT_W-1:0] LV_P1 = OUT_W'(LEVEL_UNIT);
    localparam logic [OUT_W-1:0] LV_M1 = OUT_W'(-LEVEL_UNIT);
    localparam logic [OUT_W-1:0] LV_M3 = OUT_W'(-3 * LEVEL_UNIT);
    p_level_legal_r5: assert property (@(posedge clk) disable iff (!rst_s)
      sym_vld |-> ((i_sym == LV_P3 || i_sym == LV_P1 || i_sym == LV_M1 || i_sym == LV_M3) &&
                   (q_sym == LV_P3 || q_sym == LV_P1 || q_sym == LV_M1 || q_sym == LV_M3)));
  end

endmodule

// File: tb/qam16_prbs_src_tb.sv
module qam16_prbs_src_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PERIOD_SYMS = 127;

  logic       clk;
  logic       rst_n;
  logic       en;
  logic [7:0] i_sym, q_sym;
  logic       sym_vld;

  int checks = 0;
  int errors = 0;
  string data_tag = "R5";
  bit logging = 0;
  int sym_log[$];

  qam16_prbs_src u_dut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .i_sym(i_sym), .q_sym(q_sym), .sym_vld(sym_vld)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference (R2 recurrence, R4 grouping, R5 Gray map)
  int mstate;
  int bitq[$];
  int exp_i, exp_q;
  bit exp_v;

  function automatic int gmap(input int hi, input int lo);
    case ({hi[0], lo[0]})
      2'b00:   return -96;
      2'b01:   return -32;
      2'b11:   return 32;
      default: return 96;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mstate = 127; bitq.delete(); exp_i = 0; exp_q = 0; exp_v = 0;
    end else if (en) begin
      int b;
      b = ((mstate >> 6) ^ (mstate >> 2)) & 1;
      mstate = ((mstate << 1) | b) & 127;
      bitq.push_back(b);
      if (bitq.size() == 4) begin
        exp_i = gmap(bitq[0], bitq[1]);
        exp_q = gmap(bitq[2], bitq[3]);
        exp_v = 1;
        bitq.delete();
      end else exp_v = 0;
    end else exp_v = 0;
  end

  // Per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (sym_vld !== exp_v) begin
        errors++;
        $display("FAIL R4 strobe: got %0b expected %0b", sym_vld, exp_v);
      end
      checks++;
      if ($signed(i_sym) != exp_i || $signed(q_sym) != exp_q) begin
        errors++;
        $display("FAIL %s I/Q: got %0d/%0d expected %0d/%0d", data_tag,
                 $signed(i_sym), $signed(q_sym), exp_i, exp_q);
      end
      if (logging && sym_vld) sym_log.push_back({i_sym, q_sym});
    end
  end

  task automatic expect_reset_state(input string tag);
    checks++;
    if (sym_vld !== 1'b0 || i_sym !== 8'd0 || q_sym !== 8'd0) begin
      errors++;
      $display("FAIL %s reset state: got vld=%0b I=%0d Q=%0d expected 0/0/0",
               tag, sym_vld, i_sym, q_sym);
    end
  endtask

  task automatic first_symbol_check();
    // R8: bits 0,0,0,1 from the all-ones seed
    en = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (sym_vld !== 1'b1 || $signed(i_sym) != -96 || $signed(q_sym) != -32) begin
      errors++;
      $display("FAIL R8 first symbol: got vld=%0b I=%0d Q=%0d expected 1/-96/-32",
               sym_vld, $signed(i_sym), $signed(q_sym));
    end
  endtask

  initial begin
    rst_n = 1'b0;
    en    = 1'b0;
    repeat (3) @(negedge clk);
    expect_reset_state("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_reset_state("R1");

    // Uninterrupted run, logged for the period test
    logging = 1;
    first_symbol_check();
    repeat (1200) @(negedge clk);
    logging = 0;

    // R3: stream repeats every 127 symbols
    for (int k = PERIOD_SYMS; k < sym_log.size(); k++) begin
      checks++;
      if (sym_log[k] != sym_log[k-PERIOD_SYMS]) begin
        errors++;
        $display("FAIL R3 period: symbol %0d got %h expected %h",
                 k, sym_log[k], sym_log[k-PERIOD_SYMS]);
      end
    end

    // Irregular enable gaps (R4, R6, R7)
    data_tag = "R7";
    for (int c = 0; c < 800; c++) begin
      en = ((c % 5) != 0) && ((c % 7) != 3);
      @(negedge clk);
    end

    // Long hold with enable low, then resume
    data_tag = "R6";
    en = 1'b0;
    repeat (25) @(negedge clk);
    en = 1'b1;
    data_tag = "R5";
    repeat (60) @(negedge clk);

    // Reset in the middle of a run
    rst_n = 1'b0;
    en    = 1'b0;
    @(negedge clk);
    expect_reset_state("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_reset_state("R1");
    first_symbol_check();
    repeat (40) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule